// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block watches over running software. An 8-bit counter advances once per watchdog tick. The tick comes from the oscillator clock through a fixed divide-by-512 stage and then a selectable power-of-two prescaler. If software lets the counter reach its top value (255), the block drives an active-low pulse 512 oscillator cycles long. A mode bit sends the pulse to either a reset output or an interrupt output.

To keep the pulse from firing, software services the watchdog by writing two key bytes in a fixed order: 0x55 first, then 0xAA. Every write to the control register must carry a fixed check pattern. A control write without that pattern is treated as a fault and fires the pulse at once.

All configuration and observation goes through a small synchronous register port. Reads are combinational from the selected address. The port gives access to control, key, counter and status.

Top module: `wdog_keyed`

Register map (8-bit data):
- Address 0, control (read/write): bits 2:0 select the prescaler, bits 5:3 are the check field (write 101, read back as 000), bit 6 disables counting, bit 7 is reserved (reads 0).
- Address 1, key (write only, reads 0).
- Address 2, counter (read only).
- Address 3, status/mode: bit 0 is the mode (0 = reset, 1 = interrupt) and is writable; bit 1 is read only and is 1 while the interrupt pulse is active.

## Requirements
- R1: After reset both pulse outputs are high, the counter reads 0, control reads 0x00 (divide-by-1, counting enabled) and status reads 0x00 (reset mode).
- R2: The counter advances once every 512 × N oscillator cycles, where N is 1 for prescale codes 0 and 1, and 2^(code−1) for codes 2 to 7. The counter value is readable at address 2.
- R3: The tick that takes the counter to 255 starts the pulse on the next clock edge. The counter then wraps to 0 on the following tick, so a fresh overflow comes 256 ticks after the previous one.
- R4: Writing 0x55 and then 0xAA to the key address clears the counter and restarts the divider chain. Writing 0xAA and then 0x55 does not clear the counter.
- R5: Key values other than 0x55 and 0xAA are ignored and leave an armed sequence armed. A 0xAA with no 0x55 armed before it does nothing. A repeated 0x55 keeps the sequence armed.
- R6: While control bit 6 is 1, the counter holds its value and no overflow occurs.
- R7: Each pulse holds its output low for exactly 512 oscillator cycles. The pulse goes to the reset output in reset mode and to the interrupt output in interrupt mode, and the other output stays high.
- R8: A control write whose bits 5:3 differ from 101 starts the pulse on that clock edge, in the current mode, and leaves the prescale and disable fields unchanged.
- R9: Status bit 1 reads 1 exactly while the interrupt pulse is being driven, and 0 otherwise.
- R10: Writing reset mode while the interrupt pulse is active drives the reset output low from the cycle after the write, for the rest of the pulse, and releases the interrupt output.
- R11: The interrupt output falls once per overflow. After a pulse ends it stays high until a later overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| regWe | input | 1 | Register write strobe, sampled on the rising clock edge |
| regAddr | input | 2 | Register address for reads and writes |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data for the current address (combinational) |
| wdRstN | output | 1 | Active-low reset pulse |
| wdIntN | output | 1 | Active-low interrupt pulse |

## Verification
On every cycle, the embedded properties check the following: a valid key pair clears the counter, a disabled counter holds, a pulse starts loaded with its full length and ends when that length runs out, a rejected control write leaves the configuration untouched, and a service disarms the key sequence. Only the directed scenarios can show the end-to-end timing. These cover the exact overflow distance for several prescale codes, the 512-cycle pulse width, which output carries the pulse, the wrap-around spacing between successive interrupts, and the ignored key orderings. The scenarios also cover the reset taking over when the mode changes in the middle of an interrupt pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [2:0] CHK_PATTERN = 3'b101;
  localparam int PRE_BITS = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_KEY   = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_STAT  = 2'd3
  } regAddr_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic                service;  // valid key pair completed
    logic                fire;     // check-field violation
    logic                hold;     // counting disabled
    logic                modeInt;  // 1 = interrupt mode
    logic [PRE_BITS-1:0] preSel;   // prescale code
  } wdCmd_t;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             pulseActive,
  output logic [7:0]       regRdata,
  output wdCmd_t           cmd
);

  logic [PRE_BITS-1:0] preSelQ;
  logic                disQ;
  logic                modeIntQ;
  logic                armedQ;

  logic wrCtrl, wrKey, wrStat, chkOk;

  assign wrCtrl = regWe && (regAddr == ADDR_CTRL);
  assign wrKey  = regWe && (regAddr == ADDR_KEY);
  assign wrStat = regWe && (regAddr == ADDR_STAT);
  assign chkOk  = (regWdata[5:3] == CHK_PATTERN);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSelQ  <= '0;
      disQ     <= 1'b0;
      modeIntQ <= 1'b0;
    end else begin
      if (wrCtrl && chkOk) begin
        preSelQ <= regWdata[PRE_BITS-1:0];
        disQ    <= regWdata[6];
      end
      if (wrStat) modeIntQ <= regWdata[0];
    end
  end

  // key sequence detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (wrKey) begin
      if (regWdata == KEY_ARM)       armedQ <= 1'b1;
      else if (regWdata == KEY_FIRE) armedQ <= 1'b0;
    end
  end

  always_comb begin
    cmd.service = wrKey && (regWdata == KEY_FIRE) && armedQ;
    cmd.fire    = wrCtrl && !chkOk;
    cmd.hold    = disQ;
    cmd.modeInt = modeIntQ;
    cmd.preSel  = preSelQ;
  end

  // read mux
  always_comb begin
    regRdata = 8'h00;
    case (regAddr)
      ADDR_CTRL:  regRdata = {1'b0, disQ, 3'b000, preSelQ};
      ADDR_KEY:   regRdata = 8'h00;
      ADDR_COUNT: regRdata = 8'(cntVal);
      ADDR_STAT:  regRdata = {6'b0, pulseActive && modeIntQ, modeIntQ};
      default:    regRdata = 8'h00;
    endcase
  end

  // R8: a rejected control write changes no configuration
  a_r8_bad_write_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !chkOk) |=> ($stable(preSelQ) && $stable(disQ)));

  // R5: a completed pair leaves the sequence disarmed
  a_r5_service_disarms: assert property (@(posedge clk) disable iff (!rstN)
    cmd.service |=> !armedQ);

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BASE_DIV  = 512,
  parameter int PULSE_LEN = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdCmd_t           cmd,
  output logic [CNT_W-1:0] cntVal,
  output logic             pulseActive,
  output logic             wdRstN,
  output logic             wdIntN
);

  localparam int BASE_W  = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int PULSE_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam int SCALE_W = (1 << PRE_BITS) - 2;
  localparam logic [CNT_W-1:0] CNT_PRE_TOP = CNT_W'((1 << CNT_W) - 2);

  logic [BASE_W-1:0]   baseCnt;
  logic [SCALE_W-1:0]  scaleCnt;
  logic [SCALE_W-1:0]  ratioMask;
  logic [PRE_BITS-1:0] shiftAmt;
  logic [CNT_W-1:0]    cnt;
  logic [PULSE_W-1:0]  pcnt;
  logic                active;
  logic                baseTick, wdTick, overflow, fireAny, chainClr;

  assign chainClr = cmd.hold || cmd.service;
  assign baseTick = (baseCnt == BASE_W'(BASE_DIV - 1));

  // fixed divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    baseCnt <= '0;
    else if (chainClr || baseTick) baseCnt <= '0;
    else                          baseCnt <= baseCnt + 1'b1;
  end

  // selectable prescaler
  assign shiftAmt = (cmd.preSel < PRE_BITS'(2)) ? '0 : cmd.preSel - PRE_BITS'(1);

  for (genvar i = 0; i < SCALE_W; i++) begin : g_mask
    assign ratioMask[i] = (shiftAmt > PRE_BITS'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         scaleCnt <= '0;
    else if (chainClr) scaleCnt <= '0;
    else if (baseTick) scaleCnt <= scaleCnt + 1'b1;
  end

  assign wdTick   = baseTick && ((scaleCnt & ratioMask) == ratioMask) && !chainClr;
  assign overflow = wdTick && (cnt == CNT_PRE_TOP);
  assign fireAny  = overflow || cmd.fire;

  // watchdog counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.service) cnt <= '0;
    else if (wdTick)      cnt <= cnt + 1'b1;
  end

  // pulse generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      pcnt   <= '0;
    end else if (fireAny) begin
      active <= 1'b1;
      pcnt   <= PULSE_W'(PULSE_LEN - 1);
    end else if (active) begin
      if (pcnt == '0) active <= 1'b0;
      else            pcnt   <= pcnt - 1'b1;
    end
  end

  assign cntVal      = cnt;
  assign pulseActive = active;
  assign wdRstN      = !(active && !cmd.modeInt);
  assign wdIntN      = !(active && cmd.modeInt);

  // R4: service clears the counter
  a_r4_service_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmd.service |=> (cnt == '0));

  // R6: disabled counter holds
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.hold && !cmd.service) |=> $stable(cnt));

  // R3: a fire event loads a full-length pulse
  a_r3_fire_loads: assert property (@(posedge clk) disable iff (!rstN)
    fireAny |=> (active && (pcnt == PULSE_W'(PULSE_LEN - 1))));

  // R7: the pulse keeps going until its count runs out, then ends
  a_r7_pulse_continues: assert property (@(posedge clk) disable iff (!rstN)
    (active && (pcnt != '0)) |=> active);

  a_r7_pulse_ends: assert property (@(posedge clk) disable iff (!rstN)
    (active && (pcnt == '0) && !fireAny) |=> !active);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BASE_DIV  = 512,
  parameter int PULSE_LEN = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       wdRstN,
  output logic       wdIntN
);

  wdCmd_t           cmd;
  logic [CNT_W-1:0] cntVal;
  logic             pulseActive;

  wdog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .cntVal      (cntVal),
    .pulseActive (pulseActive),
    .regRdata    (regRdata),
    .cmd         (cmd)
  );

  wdog_dp #(
    .CNT_W     (CNT_W),
    .BASE_DIV  (BASE_DIV),
    .PULSE_LEN (PULSE_LEN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .cntVal      (cntVal),
    .pulseActive (pulseActive),
    .wdRstN      (wdRstN),
    .wdIntN      (wdIntN)
  );

endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;

  localparam int TB_BASE  = 4;
  localparam int TB_PULSE = 512;
  localparam int TOP      = 255;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       wdRstN, wdIntN;

  int checks = 0;
  int misses = 0;

  always #10 clk = ~clk;  // 50 MHz

  wdog_keyed #(.CNT_W(8), .BASE_DIV(TB_BASE), .PULSE_LEN(TB_PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .wdRstN(wdRstN), .wdIntN(wdIntN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic service();
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
  endtask

  task automatic waitLow(input bit useInt, output int n);
    n = 0;
    while ((useInt ? wdIntN : wdRstN) && n < 70000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic lowWidth(input bit useInt, output int w);
    w = 0;
    while (!(useInt ? wdIntN : wdRstN) && w < 2000) begin
      w++; @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rst out", wdRstN, 1);
    chk("R1 int out", wdIntN, 1);
    rd(2'd2, d); chk("R1 counter", d, 0);
    rd(2'd0, d); chk("R1 control", d, 8'h00);
    rd(2'd3, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_period(input logic [2:0] code, input bit writeCtrl);
    int n, w, r;
    logic [7:0] d;
    r = (code < 2) ? 1 : (1 << (code - 1));
    if (writeCtrl) wr(2'd0, {5'b00101, code});
    rd(2'd0, d); chk("R2 ctrl readback", d, {5'b00000, code});
    service();
    waitLow(1'b0, n);
    chk("R2 R3 overflow distance", n, TOP * TB_BASE * r);
    chk("R7 int idle in reset mode", wdIntN, 1);
    lowWidth(1'b0, w);
    chk("R7 reset pulse width", w, TB_PULSE);
    service();
  endtask

  task automatic t_count();
    logic [7:0] d;
    wr(2'd0, 8'h28);
    service();
    repeat (40) @(negedge clk);
    rd(2'd2, d); chk("R2 counter after 40 cycles", d, 10);
    service();
  endtask

  task automatic t_keys();
    logic [7:0] d;
    service();
    repeat (40) @(negedge clk);
    wr(2'd1, 8'hAA); wr(2'd1, 8'h55);
    rd(2'd2, d); chk("R4 reverse order no clear", d, 10);
    wr(2'd1, 8'h12);
    wr(2'd1, 8'hAA);
    rd(2'd2, d); chk("R5 stray key ignored, armed pair clears", d, 0);
    repeat (40) @(negedge clk);
    wr(2'd1, 8'hAA);
    rd(2'd2, d); chk("R5 unarmed AA ignored", d, 10);
    wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    rd(2'd2, d); chk("R5 repeated 55 stays armed", d, 0);
    chk("R4 no pulse after service", wdRstN, 1);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    service();
    wr(2'd0, 8'h68);
    repeat (3000) @(negedge clk);
    rd(2'd2, d); chk("R6 counter held", d, 0);
    chk("R6 no overflow", wdRstN, 1);
    rd(2'd0, d); chk("R6 disable readback", d, 8'h40);
    wr(2'd0, 8'h28);
    service();
  endtask

  task automatic t_badchk();
    logic [7:0] d;
    int w;
    service();
    wr(2'd0, 8'h2B);
    wr(2'd0, 8'h05);
    chk("R8 immediate reset pulse", wdRstN, 0);
    rd(2'd0, d); chk("R8 fields unchanged", d, 8'h03);
    lowWidth(1'b0, w);
    chk("R8 R7 pulse width", w, TB_PULSE);
    wr(2'd0, 8'h28);
    service();
  endtask

  task automatic t_interrupt();
    logic [7:0] d;
    int n, w, t;
    bit prev;
    wr(2'd3, 8'h01);
    service();
    waitLow(1'b1, n);
    chk("R7 int overflow distance", n, TOP * TB_BASE);
    chk("R7 reset idle in int mode", wdRstN, 1);
    rd(2'd3, d); chk("R9 status active", d, 8'h03);
    lowWidth(1'b1, w);
    chk("R7 int pulse width", w, TB_PULSE);
    rd(2'd3, d); chk("R9 status idle", d, 8'h01);
    // R11: next fall only on the next overflow, 256 ticks after the first
    t = w; prev = 1'b1;
    while (t < 3000) begin
      @(negedge clk); t++;
      if (prev && !wdIntN) break;
      prev = wdIntN;
    end
    chk("R11 next interrupt spacing", t, 256 * TB_BASE);
    repeat (100) @(negedge clk);
    wr(2'd3, 8'h00);
    chk("R10 reset takes over", wdRstN, 0);
    chk("R10 int released", wdIntN, 1);
    rd(2'd3, d); chk("R9 R10 status after switch", d, 8'h00);
    lowWidth(1'b0, w);
    chk("R10 remaining reset length", w, TB_PULSE - 101);
    service();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_period(3'd0, 1'b0);
    t_period(3'd1, 1'b1);
    t_period(3'd2, 1'b1);
    t_period(3'd3, 1'b1);
    t_period(3'd7, 1'b1);
    t_count();
    t_keys();
    t_disable();
    t_badchk();
    t_interrupt();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

endmodule